// File: doc/BRIEF.md
# Dual-Order Burst Address Generator

This block produces the access address for every cycle of a four-beat burst. A load cycle passes a full external address straight through and captures it as the burst start. Each advance cycle after that forms the next address of the burst. The upper address bits come from the captured start, and only the low two bits change.

A static select input chooses the order of the low bits. The linear order adds a step count to the captured low bits, modulo four. The interleaved order XORs the captured low bits with the step count. The step count goes 0, 1, 2, 3 and then wraps, so the fifth access returns to the start. A stall input freezes the block completely. The output is registered and feeds the memory-access logic one cycle after the control is sampled.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset the output address, the step count and the captured start are all zero. Advancing straight out of reset in linear order yields low bits 01, then 10.
- R2: A load (stall=0, adv=0) sampled at a rising edge makes acc_addr equal ext_addr after that edge.
- R3: During advance cycles, acc_addr bits above the low two equal those of the last loaded address.
- R4: With xor_order=0, the k-th advance after a load gives low bits (start + k) mod 4. From start 01 the sequence is 01, 10, 11, 00.
- R5: With xor_order=1, the k-th advance gives low bits start XOR (k mod 4). From start 01 the sequence is 01, 00, 11, 10, and from start 10 it is 10, 11, 00, 01.
- R6: The fourth advance after a load returns to the start address. The fifth access therefore equals the first.
- R7: While stall=1, acc_addr and the step count hold, whatever adv and ext_addr are. The burst resumes where it stopped.
- R8: Changing xor_order mid-burst affects only the addresses generated afterwards. The step count keeps running.
- R9: On advance cycles the value of ext_addr has no effect on acc_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | 1 = hold all state this cycle |
| adv | input | 1 | 0 = load ext_addr, 1 = advance the burst |
| xor_order | input | 1 | 0 = linear order, 1 = interleaved (XOR) order |
| ext_addr | input | ADDR_W | External start address |
| acc_addr | output | ADDR_W | Registered access address |

## Verification
The bench builds the block with ADDR_W=12 and the default two-bit lane. This keeps the vectors short while leaving ten upper bits, enough to catch any leak between the captured upper field and the stepped low bits. Start values 01 and 10 exercise both orderings, where the two orders differ visibly. A mid-burst order switch and stalls that carry a load command and a changing ext_addr probe the hold and ignore paths.

// File: rtl/bag_pkg.sv
package bag_pkg;
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;
endpackage

// File: rtl/bag_step_counter.sv
module bag_step_counter #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt_next
);
  logic [CNT_W-1:0] cnt_q;

  // The value the counter takes at this edge: zero on a load, one step on an advance.
  assign cnt_next = restart ? '0 : cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst)     cnt_q <= '0;
    else if (en) cnt_q <= cnt_next;
  end
endmodule

// File: rtl/bag_order_map.sv
module bag_order_map
  import bag_pkg::*;
#(
  parameter int LANE_W = 2
) (
  input  logic [LANE_W-1:0] start_lo,
  input  logic [LANE_W-1:0] step,
  input  order_e            order,
  output logic [LANE_W-1:0] lane_out
);
  logic [LANE_W-1:0] lin_lane, xor_lane;

  assign lin_lane = start_lo + step;   // wraps modulo 2**LANE_W
  assign xor_lane = start_lo ^ step;
  assign lane_out = (order == ORD_XOR) ? xor_lane : lin_lane;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bag_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LANE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall,
  input  logic              adv,
  input  logic              xor_order,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] acc_addr
);
  localparam int HI_W = ADDR_W - LANE_W;

  logic [HI_W-1:0]   start_hi_q;
  logic [LANE_W-1:0] start_lo_q;
  logic [LANE_W-1:0] step_nx;
  logic [LANE_W-1:0] lane_nx;
  logic              live;
  order_e            order_sel;

  assign live      = !stall;
  assign order_sel = order_e'(xor_order);

  bag_step_counter #(.CNT_W(LANE_W)) cnt_i (
    .clk      (clk),
    .rst      (rst),
    .en       (live),
    .restart  (!adv),
    .cnt_next (step_nx)
  );

  bag_order_map #(.LANE_W(LANE_W)) map_i (
    .start_lo (start_lo_q),
    .step     (step_nx),
    .order    (order_sel),
    .lane_out (lane_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      start_hi_q <= '0;
      start_lo_q <= '0;
      acc_addr   <= '0;
    end else if (live) begin
      if (!adv) begin
        start_hi_q <= ext_addr[ADDR_W-1:LANE_W];
        start_lo_q <= ext_addr[LANE_W-1:0];
        acc_addr   <= ext_addr;
      end else begin
        acc_addr   <= {start_hi_q, lane_nx};
      end
    end
  end
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 20,
  parameter int LANE_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              stall,
  input logic              adv,
  input logic              xor_order,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [ADDR_W-1:0] acc_addr
);
  localparam logic [LANE_W-1:0] ONE = LANE_W'(1);

  // Set while every advance since the last load or reset was linear.
  logic lin_run;
  always_ff @(posedge clk) begin
    if (rst)                    lin_run <= 1'b1;
    else if (!stall && !adv)    lin_run <= 1'b1;
    else if (!stall && xor_order) lin_run <= 1'b0;
  end

  AST_LOAD_PASS: assert property (@(posedge clk) disable iff (rst)
    (!stall && !adv) |=> acc_addr == $past(ext_addr)); // R2

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(acc_addr)); // R7

  AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (rst)
    (!stall && adv) |=> acc_addr[ADDR_W-1:LANE_W] == $past(acc_addr[ADDR_W-1:LANE_W])); // R3

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
    (lin_run && !stall && adv && !xor_order) |=>
      acc_addr[LANE_W-1:0] == $past(acc_addr[LANE_W-1:0]) + ONE); // R4
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .stall     (stall),
  .adv       (adv),
  .xor_order (xor_order),
  .ext_addr  (ext_addr),
  .acc_addr  (acc_addr)
);

// File: tb/burst_addr_gen_tb_top.sv
module burst_addr_gen_tb_top;
  localparam int AW = 12;
  localparam int VW = 4 + 3 + 2 * AW;
  localparam int NV = 21;

  // {req, stall, adv, xor_order, ext_addr, expected acc_addr}
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'd2, 3'b000, 12'hA51, 12'hA51},  // R2 load, start low 01
    {4'd4, 3'b010, 12'h000, 12'hA52},  // R4 linear
    {4'd4, 3'b010, 12'h000, 12'hA53},  // R4
    {4'd4, 3'b010, 12'h000, 12'hA50},  // R4 R3
    {4'd6, 3'b010, 12'h000, 12'hA51},  // R6 wrap
    {4'd2, 3'b001, 12'h3C6, 12'h3C6},  // R2 load, start 10
    {4'd5, 3'b011, 12'h000, 12'h3C7},  // R5 interleaved
    {4'd5, 3'b011, 12'h000, 12'h3C4},  // R5
    {4'd5, 3'b011, 12'h000, 12'h3C5},  // R5
    {4'd6, 3'b011, 12'h000, 12'h3C6},  // R6
    {4'd2, 3'b001, 12'h7F1, 12'h7F1},  // R2 load, start 01
    {4'd9, 3'b011, 12'hFFE, 12'h7F0},  // R9 ext ignored on advance
    {4'd7, 3'b111, 12'hFFF, 12'h7F0},  // R7 stalled advance
    {4'd7, 3'b101, 12'h123, 12'h7F0},  // R7 stalled load
    {4'd7, 3'b011, 12'h000, 12'h7F3},  // R7 resumes at step 2
    {4'd5, 3'b011, 12'h000, 12'h7F2},  // R5
    {4'd2, 3'b000, 12'h802, 12'h802},  // R2 load, start 10
    {4'd4, 3'b010, 12'h000, 12'h803},  // R4
    {4'd8, 3'b011, 12'h000, 12'h800},  // R8 switch to XOR at step 2
    {4'd8, 3'b010, 12'h000, 12'h801},  // R8 back to linear, step 3
    {4'd6, 3'b010, 12'h000, 12'h802}   // R6
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          stall = 1'b0, adv = 1'b0, xor_order = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] acc_addr;
  int            n_chk = 0, n_bad = 0;
  bit            done = 1'b0;

  always #2 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .LANE_W(2)) dut_i (
    .clk(clk), .rst(rst), .stall(stall), .adv(adv),
    .xor_order(xor_order), .ext_addr(ext_addr), .acc_addr(acc_addr)
  );

  task automatic check(input string req, input logic [AW-1:0] exp);
    n_chk++;
    if (acc_addr !== exp) begin
      n_bad++;
      $display("FAIL %s acc_addr=%h expected=%h", req, acc_addr, exp);
    end
  endtask

  task automatic cyc(input logic s, input logic a, input logic x, input logic [AW-1:0] e);
    stall = s; adv = a; xor_order = x; ext_addr = e;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 12'h000);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][2*AW+2], VEC[i][2*AW+1], VEC[i][2*AW], VEC[i][2*AW-1:AW]);
      check($sformatf("R%0d vec%0d", VEC[i][VW-1:VW-4], i), VEC[i][AW-1:0]);
    end
    // R1: reset mid-burst clears the start and the count
    rst = 1'b1;
    cyc(1'b0, 1'b1, 1'b0, 12'hABC);
    check("R1 reset", 12'h000);
    rst = 1'b0;
    cyc(1'b0, 1'b1, 1'b0, 12'hFFF);
    check("R1 first step", 12'h001);
    cyc(1'b0, 1'b1, 1'b0, 12'hFFF);
    check("R1 second step", 12'h002);
    // R7: long stall with a load pending keeps the burst
    repeat (3) begin
      cyc(1'b1, 1'b0, 1'b1, 12'h555);
      check("R7 long stall", 12'h002);
    end
    cyc(1'b0, 1'b1, 1'b0, 12'h555);
    check("R7 resume", 12'h003);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule